// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block gives a host processor access to the configuration of an I/O interrupt router through a narrow 32-bit register bus. Three offsets are decoded. The first is a select register. The second is a data window whose meaning depends on the value in the select register. The third is an end-of-interrupt register. Through the window, software reaches a 4-bit controller identifier, a read-only version word, an arbitration alias of the identifier, and a table of 64-bit redirection entries. Each table entry is split across an even/odd pair of select values.

The table is kept in flops and is presented in full to the neighbouring delivery engine. A second table port lets the engine set the remote-pending bit of an entry, clear it, and drive its delivery-status bit. The window never changes those two status bits. Each accepted table write sends the engine a one-cycle service request and a one-hot request to reset that pin's storm counter. Each accepted end-of-interrupt write sends the engine a one-cycle vector broadcast. Read data is combinational from the presented address, the size and the current state. There is no read strobe.

Top module: `irq_regwin_ctrl`

## Requirements
- R1: After reset, every table entry holds 0x0000_0000_0001_0000 (only the mask bit 16 set), the identifier and the select register read 0, and the svc_req, storm_clr and eoi_valid outputs are 0.
- R2: Only address bits 7:0 are decoded. The select register is at 0x00, the data window at 0x10 and the end-of-interrupt register at 0x40. A select write of any size stores bus_wdata[7:0], and a read at 0x00 returns that value zero-extended.
- R3: A data-window access whose bus_size is not 4 is ignored. Such a read returns 0 and such a write changes nothing.
- R4: Select values 0x00 (identifier) and 0x02 (arbitration) both read the identifier in bits 27:24 with every other bit 0. A 4-byte window write with select 0x00 loads the identifier from bus_wdata[27:24]. Window writes with select 0x01 or 0x02 are ignored.
- R5: Select 0x01 reads VERSION in bits 7:0 and NPINS-1 in bits 23:16. With the defaults this gives 0x0017_0020.
- R6: Select values from 0x10 to 0x10+2*NPINS-1 reach entry (select-0x10)>>1. An odd select addresses bits 63:32 and an even select bits 31:0. Any other select that is not 0x00, 0x01 or 0x02 reads 0 and ignores writes.
- R7: Bits 14 (remote pending) and 12 (delivery status) of an entry keep their prior value across window writes. Bit 12 takes eng_dlv_stat one cycle later. Bit 14 is set by eng_rirr_set and cleared by eng_rirr_clr, and a clear wins when both arrive in the same cycle.
- R8: After a window write to either half of an entry, if bit 15 (trigger, 0 = edge) of the result is 0, then bit 14 is 0.
- R9: Each accepted table write is followed in the next cycle by a one-cycle svc_req pulse and a storm_clr vector with only that entry's bit set. At all other times both are 0.
- R10: When VERSION is 0x20, a 4-byte write at 0x40 is followed in the next cycle by a one-cycle eoi_valid pulse with eoi_vector equal to bus_wdata[7:0]. Writes of any other size produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W | Register bus address; bits 7:0 are decoded |
| bus_we | input | 1 | Write enable; when low, the address is being read |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the presented address (combinational) |
| eng_rirr_set | input | NPINS | Per-entry pulse that sets remote pending |
| eng_rirr_clr | input | NPINS | Per-entry pulse that clears remote pending |
| eng_dlv_stat | input | NPINS | Per-entry delivery-status level |
| tbl_flat | output | NPINS*64 | All entries, with entry i in bits 64*i+63 down to 64*i |
| svc_req | output | 1 | Pulse requesting a service pass after a table write |
| storm_clr | output | NPINS | One-hot reset of the storm counter of the written entry |
| eoi_valid | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vector | output | 8 | Vector carried with eoi_valid |

## Verification
Some properties are checked on every cycle. Each svc_req and eoi_valid pulse must be traced back to the bus write that caused it. The broadcast vector must match that write's data. storm_clr must be one-hot exactly while svc_req is high. An edge entry must never keep remote pending after a write to it. The version word and size-rejected window reads must have the right read values. Other behaviours can only be shown by the bench scenarios, because they need state built up over many transfers: read-only bits surviving a merge, the identifier path that responds only to select 0x00, table index boundaries and address aliasing, and the ordering between engine pulses and window writes.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;
  localparam int unsigned ENT_W      = 64;
  localparam int unsigned HALF_W     = 32;
  localparam int unsigned ID_W       = 4;
  localparam int unsigned ID_LSB     = 24;
  localparam int unsigned MAXENT_LSB = 16;

  // bus offsets (low address byte)
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] OFS_EOI = 8'h40;

  // select codes
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  // entry bit positions
  localparam int unsigned BIT_DLV  = 12;
  localparam int unsigned BIT_RIRR = 14;
  localparam int unsigned BIT_TRIG = 15;
  localparam int unsigned BIT_MASK = 16;

  localparam logic [ENT_W-1:0] RO_MASK = (ENT_W'(1) << BIT_RIRR) | (ENT_W'(1) << BIT_DLV);
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << BIT_MASK;

  typedef enum logic [1:0] {TGT_NONE, TGT_SEL, TGT_WIN, TGT_EOI} tgt_e;
  typedef enum logic [2:0] {WIN_NONE, WIN_ID, WIN_VER, WIN_ARB, WIN_TBL} win_e;
endpackage

// File: rtl/irq_regwin_rst_sync.sv
module irq_regwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
  import irq_regwin_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic [7:0]       ofs,
  input  logic [2:0]       size,
  input  logic [7:0]       sel,
  output tgt_e             tgt,
  output logic             size_ok,
  output win_e             win,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);
  localparam int unsigned SPAN = 2 * NPINS;

  logic [8:0] rel;
  logic       in_tbl;

  always_comb begin
    unique case (ofs)
      OFS_SEL: tgt = TGT_SEL;
      OFS_WIN: tgt = TGT_WIN;
      OFS_EOI: tgt = TGT_EOI;
      default: tgt = TGT_NONE;
    endcase
  end

  assign size_ok = (size == 3'd4);
  assign rel     = {1'b0, sel} - {1'b0, SEL_TBL};
  assign in_tbl  = !rel[8] && (rel < 9'(SPAN));
  assign idx     = rel[IDX_W:1];
  assign hi      = sel[0];

  always_comb begin
    if (sel == SEL_ID)       win = WIN_ID;
    else if (sel == SEL_VER) win = WIN_VER;
    else if (sel == SEL_ARB) win = WIN_ARB;
    else if (in_tbl)         win = WIN_TBL;
    else                     win = WIN_NONE;
  end
endmodule

// File: rtl/irq_regwin_entry.sv
module irq_regwin_entry
  import irq_regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              rirr_set,
  input  logic              rirr_clr,
  input  logic              dlv_stat,
  output logic [ENT_W-1:0]  ent_q
);
  logic [ENT_W-1:0] base, merged, ent_d;
  logic             ent_en;

  always_comb begin
    base           = ent_q;
    base[BIT_DLV]  = dlv_stat;
    if (rirr_set) base[BIT_RIRR] = 1'b1;
    if (rirr_clr) base[BIT_RIRR] = 1'b0;

    merged = wr_hi ? {wr_data, base[HALF_W-1:0]} : {base[ENT_W-1:HALF_W], wr_data};
    merged = (merged & ~RO_MASK) | (base & RO_MASK);
    if (!merged[BIT_TRIG]) merged[BIT_RIRR] = 1'b0;

    ent_d  = wr_en ? merged : base;
    ent_en = wr_en | rirr_set | rirr_clr | (dlv_stat != ent_q[BIT_DLV]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= ENT_RST;
    else if (ent_en) ent_q <= ent_d;
  end
endmodule

// File: rtl/irq_regwin_rdmux.sv
module irq_regwin_rdmux
  import irq_regwin_pkg::*;
#(
  parameter int unsigned NPINS   = 24,
  parameter int unsigned IDX_W   = $clog2(NPINS),
  parameter logic [7:0]  VERSION = 8'h20
) (
  input  tgt_e                   tgt,
  input  logic                   size_ok,
  input  win_e                   win,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   hi,
  input  logic [NPINS*ENT_W-1:0] ent_flat,
  input  logic [ID_W-1:0]        id,
  input  logic [7:0]             sel,
  output logic [HALF_W-1:0]      rdata
);
  localparam logic [HALF_W-1:0] VER_WORD =
    HALF_W'(VERSION) | (HALF_W'(NPINS - 1) << MAXENT_LSB);

  logic [ENT_W-1:0] ent_pick;

  assign ent_pick = ent_flat[idx*ENT_W +: ENT_W];

  always_comb begin
    rdata = '0;
    case (tgt)
      TGT_SEL: rdata = HALF_W'(sel);
      TGT_WIN: begin
        if (size_ok) begin
          case (win)
            WIN_ID, WIN_ARB: rdata = HALF_W'(id) << ID_LSB;
            WIN_VER:         rdata = VER_WORD;
            WIN_TBL:         rdata = hi ? ent_pick[ENT_W-1:HALF_W] : ent_pick[HALF_W-1:0];
            default:         rdata = '0;
          endcase
        end
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_regwin_ctrl.sv
module irq_regwin_ctrl
  import irq_regwin_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [2:0]             bus_size,
  input  logic [HALF_W-1:0]      bus_wdata,
  output logic [HALF_W-1:0]      bus_rdata,
  input  logic [NPINS-1:0]       eng_rirr_set,
  input  logic [NPINS-1:0]       eng_rirr_clr,
  input  logic [NPINS-1:0]       eng_dlv_stat,
  output logic [NPINS*ENT_W-1:0] tbl_flat,
  output logic                   svc_req,
  output logic [NPINS-1:0]       storm_clr,
  output logic                   eoi_valid,
  output logic [7:0]             eoi_vector
);
  localparam int unsigned IDX_W   = $clog2(NPINS);
  localparam logic        EOI_ENA = (VERSION == 8'h20);

  logic             rst_sn;
  logic [7:0]       ofs;
  tgt_e             tgt;
  win_e             win;
  logic             size_ok, hi;
  logic [IDX_W-1:0] idx;
  logic             unused_addr_hi;

  logic [7:0]       sel_q, sel_d;
  logic             sel_en;
  logic [ID_W-1:0]  id_q, id_d;
  logic             id_en;
  logic             win_wr, tbl_wr, eoi_fire;
  logic             svc_d;
  logic [NPINS-1:0] storm_d;
  logic             eoi_v_d;
  logic [7:0]       eoi_vec_d;

  irq_regwin_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign ofs            = bus_addr[7:0];
  assign unused_addr_hi = ^bus_addr;

  irq_regwin_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_dec (
    .ofs     (ofs),
    .size    (bus_size),
    .sel     (sel_q),
    .tgt     (tgt),
    .size_ok (size_ok),
    .win     (win),
    .idx     (idx),
    .hi      (hi)
  );

  // write qualification
  always_comb begin
    win_wr   = bus_we && (tgt == TGT_WIN) && size_ok;
    tbl_wr   = win_wr && (win == WIN_TBL);
    sel_en   = bus_we && (tgt == TGT_SEL);
    sel_d    = bus_wdata[7:0];
    id_en    = win_wr && (win == WIN_ID);
    id_d     = bus_wdata[ID_LSB +: ID_W];
    eoi_fire = EOI_ENA && bus_we && (tgt == TGT_EOI) && size_ok;
    svc_d    = tbl_wr;
    storm_d  = '0;
    if (tbl_wr) storm_d[idx] = 1'b1;
    eoi_v_d   = eoi_fire;
    eoi_vec_d = bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_en) sel_q <= sel_d;
      if (id_en)  id_q  <= id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      svc_req    <= 1'b0;
      storm_clr  <= '0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      svc_req   <= svc_d;
      storm_clr <= storm_d;
      eoi_valid <= eoi_v_d;
      if (eoi_fire) eoi_vector <= eoi_vec_d;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic wr_this;
    assign wr_this = tbl_wr && (idx == IDX_W'(g));

    irq_regwin_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_sn),
      .wr_en    (wr_this),
      .wr_hi    (hi),
      .wr_data  (bus_wdata),
      .rirr_set (eng_rirr_set[g]),
      .rirr_clr (eng_rirr_clr[g]),
      .dlv_stat (eng_dlv_stat[g]),
      .ent_q    (tbl_flat[g*ENT_W +: ENT_W])
    );
  end

  irq_regwin_rdmux #(.NPINS(NPINS), .IDX_W(IDX_W), .VERSION(VERSION)) u_rd (
    .tgt      (tgt),
    .size_ok  (size_ok),
    .win      (win),
    .idx      (idx),
    .hi       (hi),
    .ent_flat (tbl_flat),
    .id       (id_q),
    .sel      (sel_q),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/irq_regwin_chk.sv
module irq_regwin_chk
  import irq_regwin_pkg::*;
#(
  parameter int unsigned NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h20
) (
  input logic                   clk,
  input logic                   rst_sn,
  input logic [7:0]             ofs,
  input logic                   we,
  input logic [2:0]             size,
  input logic [7:0]             wdata_lo,
  input logic [HALF_W-1:0]      rdata,
  input logic [7:0]             sel_q,
  input logic [NPINS*ENT_W-1:0] tbl_flat,
  input logic                   svc_req,
  input logic [NPINS-1:0]       storm_clr,
  input logic                   eoi_valid,
  input logic [7:0]             eoi_vector
);
  localparam logic [7:0]        TBL_END  = 8'(32'(SEL_TBL) + 2 * NPINS);
  localparam logic [HALF_W-1:0] VER_EXP  = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

  logic unused_tbl;
  assign unused_tbl = ^tbl_flat;

  // R10
  eoi_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    eoi_valid |-> $past(we && ofs == OFS_EOI && size == 3'd4));

  // R10
  eoi_vec_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    eoi_valid |-> eoi_vector == $past(wdata_lo));

  // R9
  svc_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    svc_req |-> $past(we && ofs == OFS_WIN && size == 3'd4 && sel_q >= SEL_TBL && sel_q < TBL_END));

  // R9
  svc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    svc_req |-> $countones(storm_clr) == 1);

  // R9
  storm_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !svc_req |-> storm_clr == '0);

  // R3
  win_size_rd_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!we && ofs == OFS_WIN && size != 3'd4) |-> rdata == '0);

  // R5
  ver_rd_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!we && ofs == OFS_WIN && size == 3'd4 && sel_q == SEL_VER) |-> rdata == VER_EXP);

  for (genvar g = 0; g < NPINS; g++) begin : g_edge
    // R8
    edge_rirr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      ($past(we && ofs == OFS_WIN && size == 3'd4 && sel_q[7:1] == 7'(8 + g))
        && !tbl_flat[g*ENT_W + BIT_TRIG]) |-> !tbl_flat[g*ENT_W + BIT_RIRR]);
  end
endmodule

bind irq_regwin_ctrl irq_regwin_chk #(.NPINS(NPINS), .VERSION(VERSION)) chk_i (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .ofs        (bus_addr[7:0]),
  .we         (bus_we),
  .size       (bus_size),
  .wdata_lo   (bus_wdata[7:0]),
  .rdata      (bus_rdata),
  .sel_q      (sel_q),
  .tbl_flat   (tbl_flat),
  .svc_req    (svc_req),
  .storm_clr  (storm_clr),
  .eoi_valid  (eoi_valid),
  .eoi_vector (eoi_vector)
);

// File: tb/irq_regwin_ctrl_tb_top.sv
module irq_regwin_ctrl_tb_top;
  localparam int NP = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [2:0]        bus_size = 3'd4;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NP-1:0]     eng_rirr_set = '0;
  logic [NP-1:0]     eng_rirr_clr = '0;
  logic [NP-1:0]     eng_dlv_stat = '0;
  logic [NP*64-1:0]  tbl_flat;
  logic              svc_req;
  logic [NP-1:0]     storm_clr;
  logic              eoi_valid;
  logic [7:0]        eoi_vector;

  irq_regwin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_rirr_set(eng_rirr_set), .eng_rirr_clr(eng_rirr_clr),
    .eng_dlv_stat(eng_dlv_stat), .tbl_flat(tbl_flat), .svc_req(svc_req),
    .storm_clr(storm_clr), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  always #2 clk = ~clk;

  int vec_n = 0;
  int bad_n = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  bit [63:0] m_ent [NP];
  bit [7:0]  m_sel;
  bit [3:0]  m_id;
  bit        m_svc, m_eoi;
  bit [NP-1:0] m_storm;
  bit [7:0]  m_evec;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vec_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_ent[i]) m_ent[i] = 64'h1_0000;
      m_sel = 0; m_id = 0; m_svc = 0; m_storm = 0; m_eoi = 0; m_evec = 0;
    end else begin
      m_svc = 0; m_storm = 0; m_eoi = 0;
      for (int i = 0; i < NP; i++) begin
        bit [63:0] e;
        e = m_ent[i];
        e[12] = eng_dlv_stat[i];
        if (eng_rirr_set[i]) e[14] = 1'b1;
        if (eng_rirr_clr[i]) e[14] = 1'b0;
        m_ent[i] = e;
      end
      if (bus_we) begin
        if (bus_addr[7:0] == 8'h00) m_sel = bus_wdata[7:0];
        else if (bus_addr[7:0] == 8'h10 && bus_size == 3'd4) begin
          if (m_sel == 8'h00) m_id = bus_wdata[27:24];
          else if (m_sel >= 8'h10 && int'(m_sel) < 16 + 2 * NP) begin
            int k;
            bit [63:0] o, n;
            k = (int'(m_sel) - 16) / 2;
            o = m_ent[k];
            n = m_sel[0] ? {bus_wdata, o[31:0]} : {o[63:32], bus_wdata};
            n[14] = o[14];
            n[12] = o[12];
            if (!n[15]) n[14] = 1'b0;
            m_ent[k] = n;
            m_svc = 1'b1;
            m_storm[k] = 1'b1;
          end
        end else if (bus_addr[7:0] == 8'h40 && bus_size == 3'd4) begin
          m_eoi = 1'b1;
          m_evec = bus_wdata[7:0];
        end
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (run_cmp) begin
      bit bad;
      bad = 1'b0;
      vec_n++;
      for (int i = 0; i < NP; i++) begin
        if (tbl_flat[i*64 +: 64] !== m_ent[i]) begin
          if (!bad) $display("FAIL R1 R6 R7 R8 entry %0d actual=%h expected=%h", i, tbl_flat[i*64 +: 64], m_ent[i]);
          bad = 1'b1;
        end
      end
      if (svc_req !== m_svc || storm_clr !== m_storm) begin
        $display("FAIL R9 svc/storm actual=%b/%h expected=%b/%h", svc_req, storm_clr, m_svc, m_storm);
        bad = 1'b1;
      end
      if (eoi_valid !== m_eoi || (m_eoi && eoi_vector !== m_evec)) begin
        $display("FAIL R10 eoi actual=%b/%h expected=%b/%h", eoi_valid, eoi_vector, m_eoi, m_evec);
        bad = 1'b1;
      end
      if (bad) bad_n++;
    end
  end

  task automatic wr(logic [11:0] a, logic [2:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; bus_size = 3'd4;
  endtask

  task automatic rd(logic [11:0] a, logic [2:0] sz, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a; bus_size = sz;
    #1;
    chk(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic eng(logic [NP-1:0] s, logic [NP-1:0] c);
    @(negedge clk);
    eng_rirr_set = s; eng_rirr_clr = c;
    @(negedge clk);
    eng_rirr_set = '0; eng_rirr_clr = '0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad_n++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_cmp = 1'b1;

    // R1 reset state
    chk("R1 entry0 reset", tbl_flat[63:0], 64'h1_0000);
    chk("R1 entry23 reset", tbl_flat[23*64 +: 64], 64'h1_0000);
    chk("R1 strobes idle", {svc_req, eoi_valid, storm_clr}, '0);
    rd(12'h000, 3'd4, 32'h0, "R1 R2 select reset");
    rd(12'h010, 3'd4, 32'h0, "R1 R4 id reset");

    // R2 aliasing and select readback
    wr(12'hF00, 3'd4, 32'hFFFF_FF01);
    rd(12'h000, 3'd4, 32'h01, "R2 select readback");
    rd(12'h010, 3'd4, 32'h0017_0020, "R5 version word");
    rd(12'h110, 3'd4, 32'h0017_0020, "R2 window alias");
    wr(12'h000, 3'd1, 32'h0);
    rd(12'h000, 3'd2, 32'h00, "R2 select size-free write");

    // R4 identifier paths
    wr(12'h010, 3'd4, 32'hFA00_0000);
    rd(12'h010, 3'd4, 32'h0A00_0000, "R4 id write");
    wr(12'h000, 3'd4, 32'h02);
    rd(12'h010, 3'd4, 32'h0A00_0000, "R4 arb alias read");
    wr(12'h010, 3'd4, 32'h0500_0000);
    wr(12'h000, 3'd4, 32'h01);
    wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    rd(12'h010, 3'd4, 32'h0017_0020, "R4 R5 version write ignored");
    wr(12'h000, 3'd4, 32'h00);
    rd(12'h010, 3'd4, 32'h0A00_0000, "R4 arb write ignored");

    // R3 size gating
    wr(12'h010, 3'd2, 32'h0300_0000);
    rd(12'h010, 3'd4, 32'h0A00_0000, "R3 short write ignored");
    rd(12'h010, 3'd2, 32'h0, "R3 short read zero");
    rd(12'h010, 3'd1, 32'h0, "R3 byte read zero");

    // R6 R9 table halves, pin 3
    wr(12'h000, 3'd4, 32'h16);
    wr(12'h010, 3'd4, 32'h0000_8031);
    chk("R9 svc pulse", 64'(svc_req), 64'd1);
    chk("R9 storm one-hot", 64'(storm_clr), 64'h8);
    rd(12'h010, 3'd4, 32'h0000_8031, "R6 low half");
    chk("R9 pulse ends", 64'(svc_req), 64'd0);
    wr(12'h000, 3'd4, 32'h17);
    wr(12'h010, 3'd4, 32'hFF00_0000);
    rd(12'h010, 3'd4, 32'hFF00_0000, "R6 high half");
    wr(12'h000, 3'd4, 32'h16);
    rd(12'h010, 3'd4, 32'h0000_8031, "R6 low intact");

    // R7 read-only bits, R8 edge clearing
    eng(NP'(1) << 3, '0);
    rd(12'h010, 3'd4, 32'h0000_C031, "R7 engine set");
    wr(12'h010, 3'd4, 32'h0000_8031);
    rd(12'h010, 3'd4, 32'h0000_C031, "R7 rirr kept on write");
    wr(12'h010, 3'd4, 32'h0000_0031);
    rd(12'h010, 3'd4, 32'h0000_0031, "R8 edge clears rirr");
    eng(NP'(1) << 3, '0);
    rd(12'h010, 3'd4, 32'h0000_4031, "R7 set on edge entry");
    wr(12'h000, 3'd4, 32'h17);
    wr(12'h010, 3'd4, 32'h0100_0000);
    wr(12'h000, 3'd4, 32'h16);
    rd(12'h010, 3'd4, 32'h0000_0031, "R8 high-half write clears");
    wr(12'h010, 3'd4, 32'h0000_8031);
    eng(NP'(1) << 3, NP'(1) << 3);
    rd(12'h010, 3'd4, 32'h0000_8031, "R7 clear wins");
    eng(NP'(1) << 3, '0);
    eng('0, NP'(1) << 3);
    rd(12'h010, 3'd4, 32'h0000_8031, "R7 engine clear");

    // R7 delivery status, pin 5
    @(negedge clk); eng_dlv_stat = NP'(1) << 5;
    wr(12'h000, 3'd4, 32'h1A);
    wr(12'h010, 3'd4, 32'h0000_0000);
    rd(12'h010, 3'd4, 32'h0000_1000, "R7 dlv kept on write");
    @(negedge clk); eng_dlv_stat = '0;
    rd(12'h010, 3'd4, 32'h0000_0000, "R7 dlv follows engine");

    // R6 boundaries
    wr(12'h000, 3'd4, 32'h3F);
    wr(12'h010, 3'd4, 32'hAB00_0000);
    chk("R9 storm top pin", 64'(storm_clr), 64'(NP'(1) << 23));
    rd(12'h010, 3'd4, 32'hAB00_0000, "R6 last entry high");
    wr(12'h000, 3'd4, 32'h3E);
    rd(12'h010, 3'd4, 32'h0001_0000, "R6 last entry low");
    wr(12'h000, 3'd4, 32'h40);
    wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    chk("R6 R9 no svc out of range", 64'(svc_req), 64'd0);
    rd(12'h010, 3'd4, 32'h0, "R6 out of range read");
    wr(12'h000, 3'd4, 32'h0F);
    rd(12'h010, 3'd4, 32'h0, "R6 gap 0x0F");
    wr(12'h000, 3'd4, 32'h03);
    rd(12'h010, 3'd4, 32'h0, "R6 gap 0x03");

    // R10 end of interrupt
    wr(12'h040, 3'd4, 32'h1234_5677);
    chk("R10 eoi pulse", {eoi_valid, eoi_vector}, {1'b1, 8'h77});
    @(negedge clk);
    chk("R10 eoi ends", 64'(eoi_valid), 64'd0);
    wr(12'h040, 3'd1, 32'h0000_0055);
    chk("R10 short eoi ignored", 64'(eoi_valid), 64'd0);
    wr(12'h140, 3'd4, 32'h0000_00AA);
    chk("R10 R2 eoi alias", {eoi_valid, eoi_vector}, {1'b1, 8'hAA});

    repeat (3) @(negedge clk);
    run_cmp = 1'b0;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end
endmodule